// File: doc/BRIEF.md
# Reciprocal Square Root Operand Preparation Stage

This block is the front end of a single-precision reciprocal square root unit that works from a table seed and then refines it. Each valid cycle it accepts one 32-bit IEEE-754 single-precision bit pattern. Special inputs are settled on the spot: infinities and negative nonzero values become NaN with an invalid flag, and zero gives a fixed result of 1.0. Every other input is marked for refinement.

For refinement inputs whose biased exponent is small, the operand is multiplied exactly by 2^64. This includes subnormals, which are normalised in the process. A distinctive adjust code is attached so that the later stages can correct the final exponent. The block is one registered stage. Each output word appears one clock after the input is accepted.

Top module: `rsqrt_prep`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. It is low after reset.
- R2: An infinity (exponent bits 30:23 all ones, mantissa bits 22:0 zero, either sign) makes `out_op` and `out_res` 0xFFFFFFFF, with `out_adj` 0 and `out_refine` 0. `out_invalid` is raised when mantissa bit 22 of the input is clear.
- R3: A negative nonzero input (bit 31 set and bits 30:0 not all zero, including negative NaNs and negative subnormals) makes `out_op` and `out_res` 0xFFFFFFFF, with `out_invalid` 1, `out_adj` 0 and `out_refine` 0.
- R4: A zero input (bits 30:0 zero, either sign) passes through unchanged on `out_op`, gives `out_res` 0x3F800000, and leaves `out_invalid`, `out_adj` and `out_refine` at 0.
- R5: Any other input with biased exponent 25 or more, positive NaNs included, passes through unchanged, with `out_adj` 0, `out_res` 0, `out_refine` 1 and `out_invalid` 0.
- R6: Any other input with biased exponent 1 to 24 gets 64 added to its exponent field, with sign and mantissa kept. `out_adj` is 0xE0, `out_res` is 0, and `out_refine` is 1.
- R7: A positive subnormal (exponent 0, mantissa nonzero) is multiplied exactly by 2^64 and normalised. If its leading mantissa one is at bit p, the exponent becomes p+42 and the mantissa is the remaining bits shifted left by 23-p. `out_adj` is 0xE0 and `out_refine` is 1.
- R8: `out_invalid` is high only together with `out_valid`. In a cycle after `in_valid` low, `out_op`, `out_res`, `out_adj` and `out_refine` keep their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| in_op | input | 32 | Operand bit pattern |
| out_valid | output | 1 | Result fields present this cycle |
| out_op | output | 32 | Adjusted operand |
| out_res | output | 32 | Direct result word, 0 when refinement is needed |
| out_adj | output | 8 | Exponent adjust code |
| out_refine | output | 1 | Refinement still required |
| out_invalid | output | 1 | Invalid-operation pulse |

## Verification
Every result field is due exactly one rising edge after the input is presented. The bench drives the input on a falling edge and compares all fields on the next falling edge, half a period after the capturing edge. Idle cycles are inserted into the sweep, and at those points the held fields and the low valid and invalid outputs are compared one falling edge after `in_valid` drops. The sweep covers every exponent value, both signs and a spread of mantissas.

// File: rtl/rsqrt_prep_pkg.sv
package rsqrt_prep_pkg;
  localparam int EXP_W    = 8;
  localparam int MAN_W    = 23;
  localparam int WORD_W   = 1 + EXP_W + MAN_W;
  localparam int SIGN_POS = WORD_W - 1;
  localparam int BIAS     = (1 << (EXP_W - 1)) - 1;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [EXP_W-1:0]  exp_t;
  typedef logic [MAN_W-1:0]  man_t;

  localparam word_t NAN_WORD = '1;
  localparam word_t ONE_WORD = {1'b0, exp_t'(BIAS), man_t'(0)};

  function automatic exp_t f_exp(word_t w);
    return w[SIGN_POS-1 -: EXP_W];
  endfunction

  function automatic man_t f_man(word_t w);
    return w[MAN_W-1:0];
  endfunction

  // exact multiplication by 2^shift of a finite, nonzero, small-exponent word
  function automatic word_t f_scale(word_t w, int shift);
    logic [MAN_W:0] m;
    int             ne;
    if (f_exp(w) != '0) begin
      ne = int'(f_exp(w)) + shift;
      m  = {1'b1, f_man(w)};
    end else begin
      ne = 1 + shift;
      m  = {1'b0, f_man(w)};
      for (int i = 0; i < MAN_W; i++) begin
        if (!m[MAN_W]) begin
          m  = m << 1;
          ne = ne - 1;
        end
      end
    end
    return {w[SIGN_POS], exp_t'(ne), m[MAN_W-1:0]};
  endfunction
endpackage

// File: rtl/rsqrt_prep_classify.sv
module rsqrt_prep_classify
  import rsqrt_prep_pkg::*;
(
  input  word_t op_i,
  output logic  hit_inf_o,
  output logic  hit_neg_o,
  output logic  hit_zero_o,
  output logic  hit_norm_o,
  output logic  quiet_o
);
  logic exp_full;
  logic man_zero;
  logic mag_zero;

  assign exp_full = &f_exp(op_i);
  assign man_zero = (f_man(op_i) == '0);
  assign mag_zero = (f_exp(op_i) == '0) && man_zero;

  // fixed priority: infinity, negative, zero, then everything else
  assign hit_inf_o  = exp_full && man_zero;
  assign hit_neg_o  = !hit_inf_o && op_i[SIGN_POS] && !mag_zero;
  assign hit_zero_o = !hit_inf_o && mag_zero;
  assign hit_norm_o = !(hit_inf_o || hit_neg_o || hit_zero_o);
  assign quiet_o    = op_i[MAN_W-1];
endmodule

// File: rtl/rsqrt_prep_scale.sv
module rsqrt_prep_scale
  import rsqrt_prep_pkg::*;
#(
  parameter int SHIFT     = 64,
  parameter int SMALL_MAX = 24
) (
  input  word_t op_i,
  output word_t op_o,
  output logic  small_o
);
  assign small_o = int'(f_exp(op_i)) <= SMALL_MAX;

  generate
    if (SHIFT == 0) begin : g_pass
      assign op_o = op_i;
    end else begin : g_mul
      assign op_o = small_o ? f_scale(op_i, SHIFT) : op_i;
    end
  endgenerate
endmodule

// File: rtl/rsqrt_prep.sv
module rsqrt_prep
  import rsqrt_prep_pkg::*;
#(
  parameter int               SMALL_EXP_MAX = 24,
  parameter int               SCALE_POW     = 64,
  parameter int               ADJ_W         = 8,
  parameter logic [ADJ_W-1:0] ADJ_SCALED    = 8'hE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       in_op,
  output logic              out_valid,
  output logic [31:0]       out_op,
  output logic [31:0]       out_res,
  output logic [ADJ_W-1:0]  out_adj,
  output logic              out_refine,
  output logic              out_invalid
);
  logic  hit_inf, hit_neg, hit_zero, hit_norm, quiet;
  logic  scale_hit;
  word_t scaled_op;

  rsqrt_prep_classify u_cls (
    .op_i       (in_op),
    .hit_inf_o  (hit_inf),
    .hit_neg_o  (hit_neg),
    .hit_zero_o (hit_zero),
    .hit_norm_o (hit_norm),
    .quiet_o    (quiet)
  );

  rsqrt_prep_scale #(
    .SHIFT     (SCALE_POW),
    .SMALL_MAX (SMALL_EXP_MAX)
  ) u_scl (
    .op_i    (in_op),
    .op_o    (scaled_op),
    .small_o (scale_hit)
  );

  word_t             nxt_op, nxt_res;
  logic [ADJ_W-1:0]  nxt_adj;
  logic              nxt_ref, nxt_inv;

  always_comb begin
    nxt_op  = in_op;
    nxt_res = '0;
    nxt_adj = '0;
    nxt_ref = 1'b0;
    nxt_inv = 1'b0;
    if (hit_inf) begin
      nxt_op  = NAN_WORD;
      nxt_res = NAN_WORD;
      nxt_inv = !quiet;
    end else if (hit_neg) begin
      nxt_op  = NAN_WORD;
      nxt_res = NAN_WORD;
      nxt_inv = 1'b1;
    end else if (hit_zero) begin
      nxt_res = ONE_WORD;
    end else if (hit_norm) begin
      nxt_ref = 1'b1;
      if (scale_hit) begin
        nxt_op  = scaled_op;
        nxt_adj = ADJ_SCALED;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_invalid <= 1'b0;
      out_op      <= '0;
      out_res     <= '0;
      out_adj     <= '0;
      out_refine  <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      out_invalid <= in_valid && nxt_inv;
      if (in_valid) begin
        out_op     <= nxt_op;
        out_res    <= nxt_res;
        out_adj    <= nxt_adj;
        out_refine <= nxt_ref;
      end
    end
  end
endmodule

// File: rtl/rsqrt_prep_chk.sv
module rsqrt_prep_chk #(
  parameter int               ADJ_W      = 8,
  parameter logic [ADJ_W-1:0] ADJ_SCALED = 8'hE0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             out_valid,
  input logic [31:0]      out_op,
  input logic [31:0]      out_res,
  input logic [ADJ_W-1:0] out_adj,
  input logic             out_refine,
  input logic             out_invalid,
  input logic             hit_inf,
  input logic             hit_neg,
  input logic             hit_zero,
  input logic             hit_norm
);
  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R8
  invalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_invalid |-> out_valid);
  // R3
  invalid_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_invalid |-> (out_op == 32'hFFFF_FFFF && out_res == 32'hFFFF_FFFF && !out_refine));
  // R5
  refine_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_refine) |-> (out_res == 32'h0 && !out_invalid));
  // R6
  adj_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_adj != '0) |-> (out_refine && out_adj == ADJ_SCALED));
  // R4
  zero_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && hit_zero) |=> (out_res == 32'h3F80_0000 && !out_invalid && !out_refine));
  // R2
  class_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $countones({hit_inf, hit_neg, hit_zero, hit_norm}) == 1);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_op) && $stable(out_res) && $stable(out_adj) && $stable(out_refine)));
endmodule

bind rsqrt_prep rsqrt_prep_chk #(.ADJ_W(ADJ_W), .ADJ_SCALED(ADJ_SCALED)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .out_valid   (out_valid),
  .out_op      (out_op),
  .out_res     (out_res),
  .out_adj     (out_adj),
  .out_refine  (out_refine),
  .out_invalid (out_invalid),
  .hit_inf     (hit_inf),
  .hit_neg     (hit_neg),
  .hit_zero    (hit_zero),
  .hit_norm    (hit_norm)
);

// File: tb/rsqrt_prep_tb_top.sv
`timescale 1ns/1ps
module rsqrt_prep_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_op = '0;
  logic        out_valid;
  logic [31:0] out_op, out_res;
  logic [7:0]  out_adj;
  logic        out_refine, out_invalid;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rsqrt_prep dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .out_valid(out_valid), .out_op(out_op), .out_res(out_res),
    .out_adj(out_adj), .out_refine(out_refine), .out_invalid(out_invalid)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // independent arithmetic model of the requirements
  task automatic model(input logic [31:0] x, output logic [31:0] eop, output logic [31:0] eres,
                       output logic [7:0] eadj, output logic eref, output logic einv,
                       output string req);
    int e, m, p;
    e = int'(x[30:23]);
    m = int'(x[22:0]);
    eop = x; eres = 32'h0; eadj = 8'h0; eref = 1'b0; einv = 1'b0;
    if (e == 255 && m == 0) begin
      req = "R2"; eop = 32'hFFFF_FFFF; eres = 32'hFFFF_FFFF; einv = (x[22] == 1'b0);
    end else if (x[31] && x[30:0] != 0) begin
      req = "R3"; eop = 32'hFFFF_FFFF; eres = 32'hFFFF_FFFF; einv = 1'b1;
    end else if (x[30:0] == 0) begin
      req = "R4"; eres = 32'h3F80_0000;
    end else begin
      eref = 1'b1;
      if (e > 24) begin
        req = "R5";
      end else if (e > 0) begin
        req = "R6"; eadj = 8'hE0;
        eop = {x[31], 8'(e + 64), x[22:0]};
      end else begin
        req = "R7"; eadj = 8'hE0;
        p = $clog2(m + 1) - 1;
        eop = {1'b0, 8'(p + 42), 23'((m - (1 << p)) << (23 - p))};
      end
    end
  endtask

  logic [31:0] last_op, last_res;
  logic [7:0]  last_adj;
  logic        last_ref;

  task automatic send(logic [31:0] x);
    logic [31:0] eop, eres;
    logic [7:0]  eadj;
    logic        eref, einv;
    string       req;
    model(x, eop, eres, eadj, eref, einv, req);
    in_valid = 1'b1;
    in_op    = x;
    @(negedge clk);
    chk("R1", "valid", {31'b0, out_valid}, 32'd1);
    chk(req, "op", out_op, eop);
    chk(req, "res", out_res, eres);
    chk(req, "adj", {24'b0, out_adj}, {24'b0, eadj});
    chk(req, "refine", {31'b0, out_refine}, {31'b0, eref});
    chk(req, "invalid", {31'b0, out_invalid}, {31'b0, einv});
    last_op = eop; last_res = eres; last_adj = eadj; last_ref = eref;
  endtask

  task automatic idle(logic [31:0] junk);
    in_valid = 1'b0;
    in_op    = junk;
    @(negedge clk);
    chk("R1", "valid low", {31'b0, out_valid}, 32'd0);
    chk("R8", "invalid low", {31'b0, out_invalid}, 32'd0);
    chk("R8", "op hold", out_op, last_op);
    chk("R8", "res hold", out_res, last_res);
    chk("R8", "adj hold", {24'b0, out_adj}, {24'b0, last_adj});
    chk("R8", "refine hold", {31'b0, out_refine}, {31'b0, last_ref});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [22:0] mans [8];
    int          n;
    mans[0] = 23'h000000; mans[1] = 23'h000001; mans[2] = 23'h400000; mans[3] = 23'h7FFFFF;
    mans[4] = 23'h123456; mans[5] = 23'h000100; mans[6] = 23'h3FFFFF; mans[7] = 23'h0A5A5A;
    repeat (3) @(negedge clk);
    chk("R1", "reset valid", {31'b0, out_valid}, 32'd0);
    chk("R8", "reset invalid", {31'b0, out_invalid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle after reset", {31'b0, out_valid}, 32'd0);
    n = 0;
    for (int s = 0; s < 2; s++) begin
      for (int e = 0; e < 256; e++) begin
        for (int k = 0; k < 8; k++) begin
          send({s[0], e[7:0], mans[k]});
          n++;
          if (n % 37 == 0) idle({~s[0], ~e[7:0], ~mans[k]});
        end
      end
    end
    // boundary exponents around the scaling limit, and signed zeros
    send(32'h0C00_0000);
    send(32'h0C80_0000);
    send(32'h8000_0000);
    idle(32'hFF80_0000);
    send(32'h7FC0_0001);
    send(32'hFF80_0000);
    idle(32'h0000_0000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule